// File: doc/BRIEF.md
# Integrity-Protected Word Memory Responder

This block is a memory target that sits at the far end of a request/grant/response handshake. A requester presents a word-aligned byte address, a write enable, a 4-bit byte enable, 32 bits of write data and 7 check bits, all together with `req`. The responder grants in the same cycle. It answers every granted request exactly once, one cycle later, and the answers come back in the order the requests were made.

Reads return the whole stored word. Each read response also carries 7 check bits that are computed afresh over that word. Every write word is tested against the check bits that arrive with it before it is stored. A word whose check bits do not agree is discarded and reported as an error. Requests to word indices at or beyond the configured depth never touch the array and are answered with an error.

The check bits come from a (39,32) Hsiao single-error-correcting, double-error-detecting code. The 39-bit codeword is the check field placed above the data field. Each data bit has an odd-weight (weight 3) column, and each check bit is the XOR of the data bits whose column includes it.

Top module: `intg_mem_responder`

## Requirements
- R1: While `rst_n` is low and after its release with no request made, `rvalid` and `err` are 0 and `rdata`/`rchk` read as zero.
- R2: `gnt` equals `req` in every cycle, so a request is granted in the cycle it is first presented.
- R3: Each cycle with `req` high produces exactly one cycle of `rvalid` on the next clock edge. A cycle without `req` produces no `rvalid` on the next edge, and responses arrive in request order.
- R4: A read of an in-range word returns the full 32-bit stored word with `err` 0, whatever the byte enable.
- R5: A write with correct check bits updates only the bytes whose byte-enable bit is set, where bit k selects data bits 8k+7..8k.
- R6: On every response, `rchk` is the Hsiao encoding of `rdata`. Data columns are the 7-bit values of weight 3 in increasing numeric order, leaving out 0x07, 0x38 and 0x43, and data bit i takes the i-th such value. Check bit j is the XOR of the data bits whose column has bit j set.
- R7: A write whose `wchk` differs from the encoding of its `wdata` leaves the memory unchanged and gets `err` 1 on its response.
- R8: A write with matching check bits and an in-range address gets `err` 0 and `rdata` 0 on its response.
- R9: A request whose word index (address bits above bit 1) is at or beyond DEPTH gets `err` 1, `rdata` 0 and `rchk` 0. It changes no stored word, including the word its low index bits would alias onto.
- R10: Address bits 1..0 are ignored: they select neither a different word nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request present |
| gnt | output | 1 | Request accepted this cycle |
| addr | input | ADDR_W | Byte address; word index is bits ADDR_W-1..2 |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enable for writes |
| wdata | input | 32 | Write data |
| wchk | input | 7 | Check bits accompanying write data |
| rvalid | output | 1 | Response valid for one cycle |
| rdata | output | 32 | Read data (zero on write and error responses) |
| rchk | output | 7 | Check bits computed over rdata |
| err | output | 1 | Request could not be handled |

## Verification
The grant is combinational, so the bench compares `gnt` with `req` at the clock edge itself, while `req` is still stable. Every other result is due one edge after its request. The bench takes the request state at a rising edge, and 1 ns later checks the presence of `rvalid`, then `err`, `rdata` and `rchk` against the head of an in-order queue of expected responses. That queue is filled by a behavioural memory model when the request is driven. Writes that should have no effect, such as corrupted check bits, out-of-range addresses and disabled byte lanes, are confirmed by later reads through the same ports.

// File: rtl/intg_mem_pkg.sv
package intg_mem_pkg;

   localparam int WORD_W = 32;
   localparam int CHK_W  = 7;
   localparam int LANES  = WORD_W / 8;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [CHK_W-1:0]  chk_t;

   // Three weight-3 columns are dropped so that each row ends up with 13 or 14 ones.
   function automatic logic col_dropped(int v);
      return (v == 'h07) || (v == 'h38) || (v == 'h43);
   endfunction

   // Column of the parity-check matrix belonging to one data bit.
   function automatic chk_t data_column(int unsigned bit_idx);
      chk_t        res  = '0;
      int unsigned seen = 0;
      for (int v = 1; v < (1 << CHK_W); v++) begin
         if ($countones(v) == 3 && !col_dropped(v)) begin
            if (seen == bit_idx) res = chk_t'(v);
            seen++;
         end
      end
      return res;
   endfunction

   // Data bits feeding one check bit.
   function automatic word_t row_mask(int unsigned row);
      word_t m = '0;
      for (int unsigned b = 0; b < WORD_W; b++) begin
         chk_t c = data_column(b);
         m[b] = c[row];
      end
      return m;
   endfunction

   // Column-wise encoder, used by the assertions as an independent form.
   function automatic chk_t encode_cols(word_t d);
      chk_t acc = '0;
      for (int unsigned b = 0; b < WORD_W; b++) begin
         if (d[b]) acc ^= data_column(b);
      end
      return acc;
   endfunction

endpackage

// File: rtl/intg_chk_encoder.sv
module intg_chk_encoder
   import intg_mem_pkg::*;
(
   input  logic [WORD_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   for (genvar j = 0; j < CHK_W; j++) begin : g_row
      localparam word_t ROW_SEL = row_mask(j);
      assign chk[j] = ^(data & ROW_SEL);
   end

endmodule

// File: rtl/intg_word_store.sv
module intg_word_store
   import intg_mem_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANES-1:0]  lane_en,
   input  logic [WORD_W-1:0] wr_word,
   output logic [WORD_W-1:0] rd_word
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && lane_en[l]) begin
            lane_mem[idx] <= wr_word[l*8 +: 8];
         end
         if (rd_en) begin
            rd_word[l*8 +: 8] <= lane_mem[idx];
         end
      end
   end

endmodule

// File: rtl/intg_mem_responder.sv
module intg_mem_responder
   import intg_mem_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   output logic              gnt,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [3:0]        be,
   input  logic [31:0]       wdata,
   input  logic [6:0]        wchk,
   output logic              rvalid,
   output logic [31:0]       rdata,
   output logic [6:0]        rchk,
   output logic              err
);

   localparam int IDX_W  = $clog2(DEPTH);
   localparam int WIDX_W = ADDR_W - 2;

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (WIDX_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow to reach every word");
   end
   if (LANES != 4 || CHK_W != 7) begin : g_bad_word
      $error("port widths assume a 32-bit word with 7 check bits");
   end

   // Request decode
   logic [WIDX_W-1:0] word_idx;
   logic              in_range;
   logic [CHK_W-1:0]  wchk_calc;
   logic              wchk_ok;
   logic              wr_commit;
   logic              rd_fire;
   logic [1:0]        unused_byte_off;

   assign word_idx        = addr[ADDR_W-1:2];
   assign unused_byte_off = addr[1:0];
   assign in_range        = {1'b0, word_idx} < (WIDX_W+1)'(DEPTH);
   assign gnt             = req;

   intg_chk_encoder u_wr_enc (
      .data (wdata),
      .chk  (wchk_calc)
   );

   assign wchk_ok   = (wchk_calc == wchk);
   assign wr_commit = req && we && in_range && wchk_ok;
   assign rd_fire   = req && !we && in_range;

   // Storage
   logic [WORD_W-1:0] stored_word;

   intg_word_store #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_commit),
      .rd_en   (rd_fire),
      .idx     (word_idx[IDX_W-1:0]),
      .lane_en (be),
      .wr_word (wdata),
      .rd_word (stored_word)
   );

   // Response stage
   logic rsp_valid_q;
   logic rsp_err_q;
   logic rsp_data_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q    <= 1'b0;
         rsp_err_q      <= 1'b0;
         rsp_data_sel_q <= 1'b0;
      end else begin
         rsp_valid_q    <= req;
         rsp_err_q      <= req && (!in_range || (we && !wchk_ok));
         rsp_data_sel_q <= rd_fire;
      end
   end

   assign rvalid = rsp_valid_q;
   assign err    = rsp_err_q;
   assign rdata  = rsp_data_sel_q ? stored_word : '0;

   intg_chk_encoder u_rd_enc (
      .data (rdata),
      .chk  (rchk)
   );

   // Assertions
   assert_rsp_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> rvalid);

   assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !rvalid);

   assert_bad_chk_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && (wchk != encode_cols(wdata))) |=> err);

   assert_oob_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ({1'b0, addr[ADDR_W-1:2]} >= (WIDX_W+1)'(DEPTH)))
      |=> (err && rdata == '0 && rchk == '0));

   assert_rchk_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> (rchk == encode_cols(rdata)));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (!err && rdata == '0));

endmodule

// File: tb/test_intg_mem_responder.sv
`timescale 1ns/1ps
module test_intg_mem_responder;

   localparam int DEPTH  = 64;
   localparam int ADDR_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic              we = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [3:0]        be = '0;
   logic [31:0]       wdata = '0;
   logic [6:0]        wchk = '0;
   logic              gnt, rvalid, err;
   logic [31:0]       rdata;
   logic [6:0]        rchk;

   always #2.5 clk = ~clk;

   intg_mem_responder #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_intg_mem_responder (
      .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .addr(addr), .we(we),
      .be(be), .wdata(wdata), .wchk(wchk), .rvalid(rvalid), .rdata(rdata),
      .rchk(rchk), .err(err)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   logic [6:0]  col [32];
   logic [31:0] model [DEPTH];

   typedef struct {
      logic        e_err;
      logic [31:0] e_data;
      string       tag;
   } exp_t;
   exp_t expq[$];

   // Code columns as the requirement lists them
   initial begin
      int n = 0;
      int v = 1;
      while (v < 128) begin
         if ($countones(v) == 3 && v != 'h07 && v != 'h38 && v != 'h43) begin
            if (n < 32) col[n] = 7'(v);
            n++;
         end
         v++;
      end
   end

   function automatic logic [6:0] ref_enc(logic [31:0] d);
      logic [6:0] acc = '0;
      for (int j = 0; j < 7; j++) begin
         for (int b = 0; b < 32; b++) begin
            if (d[b] && col[b][j]) acc[j] = ~acc[j];
         end
      end
      return acc;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic issue(bit w, int word, int lowbits, logic [3:0] b,
                        logic [31:0] d, logic [6:0] cmask, string tag);
      exp_t e;
      bit   inr = (word < DEPTH);
      @(negedge clk);
      req   = 1'b1;
      we    = w;
      addr  = ADDR_W'(word * 4 + lowbits);
      be    = b;
      wdata = d;
      wchk  = ref_enc(d) ^ cmask;
      e.tag    = tag;
      e.e_err  = !inr || (w && cmask != 0);
      e.e_data = (!w && inr) ? model[word] : 32'h0;
      if (w && inr && cmask == 0) begin
         for (int k = 0; k < 4; k++) begin
            if (b[k]) model[word][k*8 +: 8] = d[k*8 +: 8];
         end
      end
      expq.push_back(e);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req = 1'b0;
         we  = 1'b0;
      end
   endtask

   // Cycle-by-cycle comparison
   always @(posedge clk) begin
      bit exp_v;
      exp_v = req && rst_n;
      if (rst_n) check("R2 gnt follows req", gnt, req);
      #1;
      if (rst_n && !done) begin
         check("R3 rvalid after request", rvalid, exp_v);
         if (exp_v && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check({e.tag, " err"}, err, e.e_err);
            check({e.tag, " rdata"}, rdata, e.e_data);
            check("R6 rchk encoding", rchk, ref_enc(e.e_data));
         end else if (!exp_v) begin
            check("R1 idle err low", err, 1'b0);
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      mismatched++;
      $display("FAIL R3 watchdog: actual running expected finished");
      done = 1;
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rvalid in reset", rvalid, 1'b0);
      check("R1 err in reset", err, 1'b0);
      check("R1 rdata in reset", rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rvalid after reset", rvalid, 1'b0);
      check("R1 rchk after reset", rchk, 7'h0);

      // R8: fill every word with good check bits
      for (int w = 0; w < DEPTH; w++) begin
         issue(1'b1, w, 0, 4'hF, 32'h1000_0000 + w * 32'h0101_0203, 7'h0, "R8 fill write");
      end
      idle(2);
      // R4: reads back-to-back and with gaps, varying byte enable
      for (int w = 0; w < DEPTH; w += 3) begin
         issue(1'b0, w, 0, 4'(w), 32'h0, 7'h0, "R4 read back");
         if (w % 2 == 1) idle(1);
      end
      // R5: partial byte writes
      issue(1'b1, 5, 0, 4'b0101, 32'hAABB_CCDD, 7'h0, "R5 partial write");
      issue(1'b1, 6, 0, 4'b1000, 32'h7700_0000, 7'h0, "R5 partial write");
      issue(1'b1, 7, 0, 4'b0000, 32'hFFFF_FFFF, 7'h0, "R5 empty write");
      issue(1'b0, 5, 0, 4'hF, 32'h0, 7'h0, "R5 read lanes");
      issue(1'b0, 6, 0, 4'hF, 32'h0, 7'h0, "R5 read lanes");
      issue(1'b0, 7, 0, 4'hF, 32'h0, 7'h0, "R5 read lanes");
      // R7: corrupted check bits, single and double flips
      issue(1'b1, 9, 0, 4'hF, 32'hDEAD_BEEF, 7'h01, "R7 bad chk write");
      issue(1'b1, 10, 0, 4'hF, 32'h0, 7'h48, "R7 bad chk write");
      issue(1'b0, 9, 0, 4'hF, 32'h0, 7'h0, "R7 read unchanged");
      issue(1'b0, 10, 0, 4'hF, 32'h0, 7'h0, "R7 read unchanged");
      idle(1);
      // R9: out of range reads and writes, then aliased words
      issue(1'b0, DEPTH, 0, 4'hF, 32'h0, 7'h0, "R9 oob read");
      issue(1'b1, DEPTH, 0, 4'hF, 32'h1234_5678, 7'h0, "R9 oob write");
      issue(1'b1, DEPTH + 5, 0, 4'hF, 32'h8765_4321, 7'h0, "R9 oob write");
      issue(1'b1, 2 * DEPTH + 1, 0, 4'hF, 32'h5555_AAAA, 7'h0, "R9 oob write");
      issue(1'b0, 0, 0, 4'hF, 32'h0, 7'h0, "R9 alias unchanged");
      issue(1'b0, 5, 0, 4'hF, 32'h0, 7'h0, "R9 alias unchanged");
      issue(1'b0, 1, 0, 4'hF, 32'h0, 7'h0, "R9 alias unchanged");
      // R10: low address bits ignored
      issue(1'b1, 12, 3, 4'hF, 32'h0BAD_F00D, 7'h0, "R10 offset write");
      issue(1'b0, 12, 0, 4'hF, 32'h0, 7'h0, "R10 aligned read");
      issue(1'b0, 12, 2, 4'hF, 32'h0, 7'h0, "R10 offset read");
      idle(3);
      // Mixed traffic
      for (int i = 0; i < 600; i++) begin
         int          sel  = $urandom_range(0, 9);
         int          word = $urandom_range(0, DEPTH + 3);
         logic [31:0] d    = $urandom();
         logic [6:0]  cm   = (sel == 0) ? 7'(1 << $urandom_range(0, 6)) : 7'h0;
         if (sel < 4) issue(1'b1, word, $urandom_range(0, 3), 4'($urandom_range(0, 15)), d, cm, "R3 mixed write");
         else if (sel < 9) issue(1'b0, word, $urandom_range(0, 3), 4'hF, 32'h0, 7'h0, "R4 mixed read");
         else idle(1);
      end
      idle(4);
      check("R3 all responses returned", 64'(expq.size()), 64'd0);
      done = 1;
      finish_run();
   end

endmodule